// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request brings the virtual address, the table base value and a bit that says whether fine tables with tiny pages are allowed. The walker issues one word read at a time on a request/response memory port. It decodes the first-level descriptor and, when that descriptor points to a second-level table, reads and decodes a second-level descriptor.

The result is a physical address, a 2-bit cacheable/bufferable attribute and a fault flag. The three are presented with a one-cycle completion pulse and stay unchanged until the next walk completes. The walker handles one walk at a time and takes a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to address {base[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with bits [1:0] = 0 ends the walk with fault=1, pa=0 and cb=0 after exactly one read.
- R3: A first-level descriptor with bits [1:0] = 3 while tiny-page support is off ends the walk with fault=1, pa=0 and cb=0 after exactly one read.
- R4: A first-level descriptor with bits [1:0] = 2 (section) ends the walk after one read with pa = {desc[31:20], va[19:0]}, cb = desc[3:2] and fault=0.
- R5: A first-level descriptor with bits [1:0] = 1 (coarse table) causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 3 while tiny-page support is on (fine table) causes a second read at {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 0 ends the walk with fault=1, pa=0 and cb=0.
- R8: A second-level descriptor with bits [1:0] = 1 gives pa = {desc[31:16], va[15:0]}.
- R9: A second-level descriptor with bits [1:0] = 2 gives pa = {desc[31:12], va[11:0]}.
- R10: A second-level descriptor with bits [1:0] = 3 gives pa = {desc[31:10], va[9:0]}.
- R11: For every non-faulting second-level page, cb equals that descriptor's bits [3:2].
- R12: req_ready is high only while the walker is idle. done is high for exactly one cycle per walk. pa, cb and fault hold their values until the next done.
- R13: mem_req is a single-cycle pulse, and no further read is issued until the response arrives. The response may arrive any number of cycles later.
- R14: While reset is high, and in the cycle after it is released, done=0, fault=0, pa=0, cb=0, mem_req=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Translation table base value |
| req_tiny_en | input | 1 | Allows fine tables with tiny pages |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address result |
| cb | output | 2 | Cacheable/bufferable attribute |
| fault | output | 1 | Translation fault flag |

## Verification
The widths of the block are fixed by the descriptor format, so the bench builds it with its only configuration: 32-bit addresses and descriptors. Random descriptors spread across all four type codes at both levels, with tiny-page support both on and off. This covers every first-level outcome and every second-level page size. Memory latency varies from zero extra cycles to twenty, which shows that the walker waits for the response rather than assuming a fixed delay.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW = 32;
  localparam int CBW = 2;
  localparam int TW = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_W1   = 3'd2,
    ST_RD2  = 3'd3,
    ST_W2   = 3'd4
  } walk_st_t;

  // descriptor type codes
  localparam logic [TW-1:0] T_NONE  = 2'd0;
  localparam logic [TW-1:0] T_ONE   = 2'd1;
  localparam logic [TW-1:0] T_TWO   = 2'd2;
  localparam logic [TW-1:0] T_THREE = 2'd3;

  function automatic logic [AW-1:0] first_addr(input logic [AW-1:0] base, input logic [AW-1:0] va);
    return {base[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [AW-1:0] coarse_addr(input logic [AW-1:0] d, input logic [AW-1:0] va);
    return {d[31:10], va[19:12], 2'b00};
  endfunction

  function automatic logic [AW-1:0] fine_addr(input logic [AW-1:0] d, input logic [AW-1:0] va);
    return {d[31:12], va[19:10], 2'b00};
  endfunction

  function automatic logic [AW-1:0] section_pa(input logic [AW-1:0] d, input logic [AW-1:0] va);
    return {d[31:20], va[19:0]};
  endfunction

  function automatic logic [AW-1:0] page_pa(input logic [AW-1:0] d, input logic [AW-1:0] va);
    logic [AW-1:0] r;
    case (d[1:0])
      T_ONE:   r = {d[31:16], va[15:0]};
      T_TWO:   r = {d[31:12], va[11:0]};
      T_THREE: r = {d[31:10], va[9:0]};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0]  desc,
  input  logic [AW-1:0]  va,
  input  logic           tiny_en,
  output logic           is_fault,
  output logic           is_leaf,
  output logic [AW-1:0]  next_addr,
  output logic [AW-1:0]  leaf_pa,
  output logic [CBW-1:0] leaf_cb
);
  logic [TW-1:0] kind;
  assign kind = desc[1:0];

  always_comb begin
    is_fault  = 1'b0;
    is_leaf   = 1'b0;
    next_addr = '0;
    case (kind)
      T_NONE:  is_fault = 1'b1;
      T_ONE:   next_addr = coarse_addr(desc, va);
      T_TWO:   is_leaf = 1'b1;
      default: begin
        if (tiny_en) next_addr = fine_addr(desc, va);
        else         is_fault = 1'b1;
      end
    endcase
  end

  assign leaf_pa = section_pa(desc, va);
  assign leaf_cb = desc[3:2];
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0]  desc,
  input  logic [AW-1:0]  va,
  output logic           is_fault,
  output logic [AW-1:0]  page_out,
  output logic [CBW-1:0] page_cb
);
  assign is_fault = (desc[1:0] == T_NONE);
  assign page_out = page_pa(desc, va);
  assign page_cb  = desc[3:2];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_va,
  input  logic [AW-1:0]  req_base,
  input  logic           req_tiny_en,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [AW-1:0]  mem_rdata,
  output logic           done,
  output logic [AW-1:0]  pa,
  output logic [CBW-1:0] cb,
  output logic           fault
);
  walk_st_t       st_q;
  logic [AW-1:0]  va_q;
  logic           tiny_q;
  logic [AW-1:0]  addr_q;
  logic           done_q;
  logic [AW-1:0]  pa_q;
  logic [CBW-1:0] cb_q;
  logic           fault_q;

  // named internal events
  logic accept;
  logic l1_resp;
  logic l2_resp;

  logic           l1_fault, l1_leaf;
  logic [AW-1:0]  l1_next, l1_pa;
  logic [CBW-1:0] l1_cb;
  logic           l2_fault;
  logic [AW-1:0]  l2_pa;
  logic [CBW-1:0] l2_cb;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign l1_resp   = (st_q == ST_W1) && mem_rvalid;
  assign l2_resp   = (st_q == ST_W2) && mem_rvalid;

  ptw_l1_dec u_l1 (
    .desc      (mem_rdata),
    .va        (va_q),
    .tiny_en   (tiny_q),
    .is_fault  (l1_fault),
    .is_leaf   (l1_leaf),
    .next_addr (l1_next),
    .leaf_pa   (l1_pa),
    .leaf_cb   (l1_cb)
  );

  ptw_l2_dec u_l2 (
    .desc     (mem_rdata),
    .va       (va_q),
    .is_fault (l2_fault),
    .page_out (l2_pa),
    .page_cb  (l2_cb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      tiny_q  <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      pa_q    <= '0;
      cb_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            va_q   <= req_va;
            tiny_q <= req_tiny_en;
            addr_q <= first_addr(req_base, req_va);
            st_q   <= ST_RD1;
          end
        end
        ST_RD1: st_q <= ST_W1;
        ST_W1: begin
          if (l1_resp) begin
            if (l1_fault) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              pa_q    <= '0;
              cb_q    <= '0;
              st_q    <= ST_IDLE;
            end else if (l1_leaf) begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              pa_q    <= l1_pa;
              cb_q    <= l1_cb;
              st_q    <= ST_IDLE;
            end else begin
              addr_q <= l1_next;
              st_q   <= ST_RD2;
            end
          end
        end
        ST_RD2: st_q <= ST_W2;
        ST_W2: begin
          if (l2_resp) begin
            done_q  <= 1'b1;
            fault_q <= l2_fault;
            pa_q    <= l2_fault ? '0 : l2_pa;
            cb_q    <= l2_fault ? '0 : l2_cb;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign pa       = pa_q;
  assign cb       = cb_q;
  assign fault    = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_va,
  input logic [AW-1:0]  req_base,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic           done,
  input logic [AW-1:0]  pa,
  input logic [CBW-1:0] cb,
  input logic           fault
);
  // R13
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R12
  done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R2
  fault_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (pa == '0 && cb == '0));

  // R1
  first_read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (mem_req && mem_addr == {$past(req_base[31:14]), $past(req_va[31:20]), 2'b00}));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_va    (req_va),
  .req_base  (req_base),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .done      (done),
  .pa        (pa),
  .cb        (cb),
  .fault     (fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic [31:0] req_base;
  logic        req_tiny_en;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] pa;
  logic [1:0]  cb;
  logic        fault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_base(req_base), .req_tiny_en(req_tiny_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .pa(pa), .cb(cb), .fault(fault)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // independent reference, written with masks and shifts
  task automatic model(input logic [31:0] va, input logic [31:0] base, input bit tiny,
                       input logic [31:0] d1, input logic [31:0] d2,
                       output int nrd, output logic [31:0] a1, output logic [31:0] a2,
                       output logic [31:0] epa, output logic [1:0] ecb, output bit ef,
                       output string pa_tag, output string cb_tag);
    a1 = (base & 32'hffffc000) | ((va & 32'hfff00000) >> 18);
    a2 = 0; epa = 0; ecb = 0; ef = 0; nrd = 1; cb_tag = "R4";
    if (d1[1:0] == 0) begin ef = 1; pa_tag = "R2"; cb_tag = "R2"; end
    else if (d1[1:0] == 3 && !tiny) begin ef = 1; pa_tag = "R3"; cb_tag = "R3"; end
    else if (d1[1:0] == 2) begin
      epa = (d1 & 32'hfff00000) | (va & 32'h000fffff);
      ecb = 2'((d1 >> 2) & 3); pa_tag = "R4";
    end else begin
      nrd = 2;
      if (d1[1:0] == 1) a2 = (d1 & 32'hfffffc00) | ((va & 32'h000ff000) >> 10);
      else              a2 = (d1 & 32'hfffff000) | ((va & 32'h000ffc00) >> 8);
      cb_tag = "R11";
      case (d2[1:0])
        2'd0: begin ef = 1; pa_tag = "R7"; cb_tag = "R7"; end
        2'd1: begin epa = (d2 & 32'hffff0000) | (va & 32'h0000ffff); pa_tag = "R8"; end
        2'd2: begin epa = (d2 & 32'hfffff000) | (va & 32'h00000fff); pa_tag = "R9"; end
        default: begin epa = (d2 & 32'hfffffc00) | (va & 32'h000003ff); pa_tag = "R10"; end
      endcase
      if (!ef) ecb = 2'((d2 >> 2) & 3);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit tiny,
                      input logic [31:0] d1, input logic [31:0] d2, input int lat);
    int nrd, seen, waitc;
    bit pend, busy_ready, got_done;
    logic [31:0] a1, a2, epa, got_a1, got_a2, hpa;
    logic [1:0]  ecb, hcb;
    logic        hf;
    bit ef;
    string pt, ct;
    model(va, base, tiny, d1, d2, nrd, a1, a2, epa, ecb, ef, pt, ct);
    seen = 0; pend = 0; waitc = 0; busy_ready = 0; got_done = 0;
    got_a1 = 0; got_a2 = 0;
    @(negedge clk);
    check("R12", "ready idle", 32'(req_ready), 1);
    req_valid = 1; req_va = va; req_base = base; req_tiny_en = tiny;
    @(negedge clk);
    req_valid = 0; req_va = $urandom; req_base = $urandom; req_tiny_en = 1'($urandom);
    for (int i = 0; i < 200; i++) begin
      if (i > 0) @(negedge clk);
      mem_rvalid = 0;
      if (done) begin got_done = 1; break; end
      if (req_ready) busy_ready = 1;
      if (mem_req) begin
        seen++;
        if (seen == 1) got_a1 = mem_addr; else if (seen == 2) got_a2 = mem_addr;
        pend = 1; waitc = lat;
      end else if (pend) begin
        if (waitc == 0) begin
          mem_rvalid = 1; mem_rdata = (seen == 1) ? d1 : d2; pend = 0;
        end else waitc--;
      end
    end
    check("R13", "done seen", 32'(got_done), 1);
    check("R12", "ready low while busy", 32'(busy_ready), 0);
    check(nrd == 2 ? "R5" : ct, "read count", seen, nrd);
    check("R1", "first addr", got_a1, a1);
    if (nrd == 2) check(d1[1:0] == 1 ? "R5" : "R6", "second addr", got_a2, a2);
    check(pt, "pa", pa, epa);
    check(ct, "cb", 32'(cb), 32'(ecb));
    check(pt, "fault", 32'(fault), 32'(ef));
    hpa = pa; hcb = cb; hf = fault;
    @(negedge clk);
    check("R12", "done one cycle", 32'(done), 0);
    check("R12", "pa held", pa, hpa);
    check("R12", "cb/fault held", {30'd0, hcb ^ cb} | 32'(hf ^ fault), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1; req_valid = 0; req_va = 0; req_base = 0; req_tiny_en = 0;
    mem_rvalid = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R14 reset state
    check("R14", "done", 32'(done), 0);
    check("R14", "fault", 32'(fault), 0);
    check("R14", "pa", pa, 0);
    check("R14", "cb", 32'(cb), 0);
    check("R14", "mem_req", 32'(mem_req), 0);
    rst = 0;
    @(negedge clk);
    check("R14", "ready after release", 32'(req_ready), 1);

    // directed corner cases
    walk(32'h12345678, 32'hABCDFFFF, 0, 32'h00000000, 0, 0);            // R2
    walk(32'hFFFFFFFF, 32'h00004000, 0, 32'h0000000F, 0, 1);            // R3
    walk(32'h89ABCDEF, 32'h11111111, 1, 32'hFED0000E, 0, 0);            // R4
    walk(32'h00ABC123, 32'h20000000, 0, 32'h40000401, 32'hCAFE000D, 2); // R5 R8 R11
    walk(32'h00ABCDEF, 32'h20000000, 1, 32'h50001003, 32'h1234500A, 0); // R6 R9
    walk(32'h7FFFFFFF, 32'h30000000, 1, 32'h6000F003, 32'hABCDEC07, 3); // R6 R10
    walk(32'h00001000, 32'h30000000, 1, 32'h60000001, 32'hFFFFFFFC, 1); // R7
    walk(32'h13579BDF, 32'h40000000, 1, 32'h70000002, 0, 20);           // R13 long wait

    for (int n = 0; n < 400; n++)
      walk($urandom, $urandom, 1'($urandom), $urandom, $urandom, int'($urandom % 4));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule